// File: doc/BRIEF.md
# Display Register Command-Stream Executor

This block walks a list of 64-bit instructions held in a local instruction memory and turns them into writes on a simple register-write master port. A host fills the memory through a word-wide load port. It sets a start pointer and the enable bit through a small control port, then writes the end pointer. That write launches execution. The engine steps from the start pointer toward the end pointer one instruction at a time. It stops when the two pointers meet, gives a one-cycle completion pulse, and sets a sticky completion flag.

Instructions can write one register with byte enables. They can also stream a counted run of data words into a single register. Other instructions stall the stream: for a number of microseconds, for a number of vertical-blank pulses, or until the current display scan line enters or leaves an inclusive window. The block only writes registers and never reads them. A running stream can be stopped at any point by writing the enable and halt bits together.

Top module: `cmdstream_exec`

## Requirements
- R1: An instruction is a pair of 32-bit words at an even word index. The first word is data. In the second word, bits 31:24 are the opcode, bits 23:20 the byte enables and bits 19:0 the register offset. Opcode 1 performs exactly one register write of the data word with those byte enables to that offset.
- R2: Opcode 0 advances to the next pair and makes no register write.
- R3: Opcode 9 takes the count N from its first word. The N words that follow the pair are written, in order, to the pair's offset with all four byte enables set. When N is odd, the single pad word after the run is skipped, so the next instruction starts at the next even index. N equal to zero writes nothing.
- R4: Opcode 2 stalls for N microseconds, where N is the data word and one microsecond is CLK_PER_US clock cycles. With N=5 and CLK_PER_US=4, busy lasts between 20 and 24 cycles for a one-instruction stream. N=0 does not stall.
- R5: Opcode 4 stalls until N pulses have been seen on the vertical-blank input.
- R6: Opcode 5 stalls until the scan line lies within lower..upper, both bounds inclusive. The window is a 40-bit field made of the data word as bits 31:0 and bits 7:0 of the second word as bits 39:32. The lower bound is field bits 19:0 and the upper bound is field bits 39:20.
- R7: Opcode 6 uses the same window field as R6 and stalls until the scan line lies outside the window.
- R8: Any other opcode, including 3, 7 and 10, makes no register write and sets the sticky error flag. Writing a 1 to bit 1 of the clear register (select 3) clears that flag.
- R9: The control port has four selects: 0 is the start pointer, 1 is the end pointer, 2 is control, and 3 is clear. A write to select 1 starts a run from the start pointer only if control bit 0 (enable) is set. busy is high from the cycle after that write until the end pointer is reached. Register writes occur only during a run.
- R10: When execution reaches the end pointer, donePulse is high for exactly one cycle as busy falls. It also sets doneIrq, which stays set until a 1 is written to bit 0 of the clear register.
- R11: Writing control with bits 1:0 = 11 while running stops the run. busy is low in the next cycle, no donePulse occurs, and no further register writes are made.
- R12: After reset, busy, donePulse, doneIrq, errFlag and regWe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memWe | input | 1 | Instruction memory write strobe |
| memAddr | input | AW | Instruction memory word index |
| memWdata | input | 32 | Instruction memory write word |
| ctlWe | input | 1 | Control port write strobe |
| ctlSel | input | 2 | Control port select (0 start, 1 end, 2 control, 3 clear) |
| ctlWdata | input | AW | Control port write value |
| scanLine | input | SL_W | Current display scan line |
| vblankPulse | input | 1 | One-cycle vertical-blank event |
| busy | output | 1 | Run in progress |
| donePulse | output | 1 | One-cycle completion event |
| doneIrq | output | 1 | Sticky completion flag |
| errFlag | output | 1 | Sticky unknown-opcode flag |
| regWe | output | 1 | Register write strobe |
| regAddr | output | 20 | Register offset |
| regData | output | 32 | Register write data |
| regBe | output | 4 | Register byte enables |

## Verification
The hardest case to reach from the ports is a window upper bound that lies on both sides of the word boundary. This can only be seen with a bound whose bits sit in the second word, together with a scan line that the truncated bound would place outside the window. The stimulus uses an upper bound of 0x1200 with a scan line of 0x1100. Stalls are checked by holding the scan line or the vblank pulses back for several cycles, then confirming that busy stays high with no writes before releasing them. Odd and even indexed runs are each followed by a direct write, so a wrong skip over the pad word appears as a stray write.

// File: rtl/cmdx_pkg.sv
package cmdx_pkg;

  localparam logic [7:0] OP_NOP     = 8'h00;
  localparam logic [7:0] OP_WRITE   = 8'h01;
  localparam logic [7:0] OP_WAITUS  = 8'h02;
  localparam logic [7:0] OP_WAITVB  = 8'h04;
  localparam logic [7:0] OP_WIN_IN  = 8'h05;
  localparam logic [7:0] OP_WIN_OUT = 8'h06;
  localparam logic [7:0] OP_BURST   = 8'h09;

  localparam logic [1:0] SEL_HEAD  = 2'd0;
  localparam logic [1:0] SEL_TAIL  = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_CLEAR = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_BURST, ST_WAITUS, ST_WAITVB, ST_WIN_IN, ST_WIN_OUT
  } state_e;

  typedef struct packed {
    logic loadPtr;
    logic step2;
    logic loadInst;
    logic issueDirect;
    logic issueBurst;
    logic decCnt;
    logic tickUs;
    logic setErr;
    logic finish;
  } strobe_t;

endpackage

// File: rtl/cmdx_ctrl.sv
module cmdx_ctrl
  import cmdx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] opcode,
  input  logic       instZeroCnt,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       inWin,
  input  logic       atTail,
  input  logic       startReq,
  input  logic       haltReq,
  input  logic       vblankPulse,
  output strobe_t    stb,
  output logic       busy
);

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    stb       = '0;
    stateNext = state;
    if (haltReq && state != ST_IDLE) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            stb.loadPtr = 1'b1;
            stateNext   = ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (atTail) begin
            stb.finish = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            case (opcode)
              OP_NOP:   stb.step2 = 1'b1;
              OP_WRITE: begin
                stb.issueDirect = 1'b1;
                stb.step2       = 1'b1;
              end
              OP_BURST: begin
                stb.step2 = 1'b1;
                if (!instZeroCnt) begin
                  stb.loadInst = 1'b1;
                  stateNext    = ST_BURST;
                end
              end
              OP_WAITUS: begin
                stb.loadInst = 1'b1;
                stateNext    = ST_WAITUS;
              end
              OP_WAITVB: begin
                stb.loadInst = 1'b1;
                stateNext    = ST_WAITVB;
              end
              OP_WIN_IN: begin
                stb.loadInst = 1'b1;
                stateNext    = ST_WIN_IN;
              end
              OP_WIN_OUT: begin
                stb.loadInst = 1'b1;
                stateNext    = ST_WIN_OUT;
              end
              default: begin
                stb.setErr = 1'b1;
                stb.step2  = 1'b1;
              end
            endcase
          end
        end
        ST_BURST: begin
          stb.issueBurst = 1'b1;
          if (cntOne) stateNext = ST_FETCH;
        end
        ST_WAITUS: begin
          if (cntZero) begin
            stb.step2 = 1'b1;
            stateNext = ST_FETCH;
          end else begin
            stb.tickUs = 1'b1;
          end
        end
        ST_WAITVB: begin
          if (cntZero) begin
            stb.step2 = 1'b1;
            stateNext = ST_FETCH;
          end else if (vblankPulse) begin
            stb.decCnt = 1'b1;
          end
        end
        ST_WIN_IN: begin
          if (inWin) begin
            stb.step2 = 1'b1;
            stateNext = ST_FETCH;
          end
        end
        ST_WIN_OUT: begin
          if (!inWin) begin
            stb.step2 = 1'b1;
            stateNext = ST_FETCH;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmdx_dpath.sv
module cmdx_dpath
  import cmdx_pkg::*;
#(
  parameter int MEM_WORDS  = 64,
  parameter int CNT_W      = 16,
  parameter int CLK_PER_US = 4,
  parameter int SL_W       = 13,
  localparam int AW    = $clog2(MEM_WORDS),
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            memWe,
  input  logic [AW-1:0]   memAddr,
  input  logic [31:0]     memWdata,
  input  logic            ctlWe,
  input  logic [1:0]      ctlSel,
  input  logic [AW-1:0]   ctlWdata,
  input  logic [SL_W-1:0] scanLine,
  input  strobe_t         stb,
  output logic [7:0]      opcode,
  output logic            instZeroCnt,
  output logic            cntZero,
  output logic            cntOne,
  output logic            inWin,
  output logic            atTail,
  output logic            startReq,
  output logic            haltReq,
  output logic            regWe,
  output logic [19:0]     regAddr,
  output logic [31:0]     regData,
  output logic [3:0]      regBe,
  output logic            donePulse,
  output logic            doneIrq,
  output logic            errFlag
);

  logic [31:0]      mem [MEM_WORDS];
  logic [AW-1:0]    ptr, head, tail, ptrNext, ptrPad;
  logic [31:0]      word0, word1;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [19:0]      burstAddr, winLo, winHi, scanExt;
  logic             enable, usWrap, cntDec, clrDone, clrErr;

  always_ff @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
  end

  assign ptrNext = ptr + AW'(1);
  assign ptrPad  = ptrNext + AW'(ptrNext[0]);
  assign word0   = mem[ptr];
  assign word1   = mem[ptrNext];

  assign opcode      = word1[31:24];
  assign instZeroCnt = (word0[CNT_W-1:0] == '0);
  assign cntZero     = (cnt == '0);
  assign cntOne      = (cnt == CNT_W'(1));
  assign atTail      = (ptr == tail);
  assign usWrap      = (pre == PRE_W'(CLK_PER_US - 1));
  assign cntDec      = stb.decCnt | stb.issueBurst | (stb.tickUs & usWrap);

  assign scanExt = 20'(scanLine);
  assign inWin   = (scanExt >= winLo) && (scanExt <= winHi);

  assign startReq = ctlWe && (ctlSel == SEL_TAIL) && enable;
  assign haltReq  = ctlWe && (ctlSel == SEL_CTRL) && (ctlWdata[1:0] == 2'b11);
  assign clrDone  = ctlWe && (ctlSel == SEL_CLEAR) && ctlWdata[0];
  assign clrErr   = ctlWe && (ctlSel == SEL_CLEAR) && ctlWdata[1];

  // host-visible pointers and enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      head   <= '0;
      tail   <= '0;
      enable <= 1'b0;
    end else if (ctlWe) begin
      case (ctlSel)
        SEL_HEAD: head   <= {ctlWdata[AW-1:1], 1'b0};
        SEL_TAIL: tail   <= {ctlWdata[AW-1:1], 1'b0};
        SEL_CTRL: enable <= ctlWdata[0];
        default:  ;
      endcase
    end
  end

  // fetch pointer, counters and latched operands
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      cnt       <= '0;
      pre       <= '0;
      burstAddr <= '0;
      winLo     <= '0;
      winHi     <= '0;
    end else begin
      if (stb.loadPtr)         ptr <= head;
      else if (stb.step2)      ptr <= ptr + AW'(2);
      else if (stb.issueBurst) ptr <= cntOne ? ptrPad : ptrNext;

      if (stb.loadInst) begin
        cnt       <= word0[CNT_W-1:0];
        pre       <= '0;
        burstAddr <= word1[19:0];
        winLo     <= word0[19:0];
        winHi     <= {word1[7:0], word0[31:20]};
      end else begin
        if (cntDec) cnt <= cnt - CNT_W'(1);
        if (stb.tickUs) pre <= usWrap ? '0 : pre + PRE_W'(1);
      end
    end
  end

  // register master port and status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWe     <= 1'b0;
      regAddr   <= '0;
      regData   <= '0;
      regBe     <= '0;
      donePulse <= 1'b0;
      doneIrq   <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      regWe     <= stb.issueDirect | stb.issueBurst;
      donePulse <= stb.finish;
      if (stb.issueDirect) begin
        regAddr <= word1[19:0];
        regData <= word0;
        regBe   <= word1[23:20];
      end else if (stb.issueBurst) begin
        regAddr <= burstAddr;
        regData <= word0;
        regBe   <= 4'hF;
      end
      if (stb.finish)   doneIrq <= 1'b1;
      else if (clrDone) doneIrq <= 1'b0;
      if (stb.setErr)   errFlag <= 1'b1;
      else if (clrErr)  errFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/cmdstream_exec.sv
module cmdstream_exec
  import cmdx_pkg::*;
#(
  parameter int MEM_WORDS  = 64,
  parameter int CNT_W      = 16,
  parameter int CLK_PER_US = 4,
  parameter int SL_W       = 13,
  localparam int AW = $clog2(MEM_WORDS)
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            memWe,
  input  logic [AW-1:0]   memAddr,
  input  logic [31:0]     memWdata,
  input  logic            ctlWe,
  input  logic [1:0]      ctlSel,
  input  logic [AW-1:0]   ctlWdata,
  input  logic [SL_W-1:0] scanLine,
  input  logic            vblankPulse,
  output logic            busy,
  output logic            donePulse,
  output logic            doneIrq,
  output logic            errFlag,
  output logic            regWe,
  output logic [19:0]     regAddr,
  output logic [31:0]     regData,
  output logic [3:0]      regBe
);

  strobe_t    stb;
  logic [7:0] opcode;
  logic       instZeroCnt, cntZero, cntOne, inWin, atTail, startReq, haltReq;

  cmdx_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .instZeroCnt(instZeroCnt),
    .cntZero(cntZero), .cntOne(cntOne), .inWin(inWin), .atTail(atTail),
    .startReq(startReq), .haltReq(haltReq), .vblankPulse(vblankPulse),
    .stb(stb), .busy(busy)
  );

  cmdx_dpath #(
    .MEM_WORDS(MEM_WORDS), .CNT_W(CNT_W), .CLK_PER_US(CLK_PER_US), .SL_W(SL_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .ctlWe(ctlWe), .ctlSel(ctlSel), .ctlWdata(ctlWdata), .scanLine(scanLine),
    .stb(stb), .opcode(opcode), .instZeroCnt(instZeroCnt), .cntZero(cntZero),
    .cntOne(cntOne), .inWin(inWin), .atTail(atTail), .startReq(startReq),
    .haltReq(haltReq), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .regBe(regBe), .donePulse(donePulse), .doneIrq(doneIrq), .errFlag(errFlag)
  );

endmodule

// File: rtl/cmdx_checker.sv
module cmdx_checker #(
  parameter int AW = 6
)(
  input logic          clk,
  input logic          rstN,
  input logic          ctlWe,
  input logic [1:0]    ctlSel,
  input logic [AW-1:0] ctlWdata,
  input logic          busy,
  input logic          donePulse,
  input logic          doneIrq,
  input logic          errFlag,
  input logic          regWe
);

  AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> $past(busy)); // R9

  AST_IDLE_NEEDS_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(ctlWe && ctlSel == 2'd1)) |=> !busy); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R10

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && $past(busy))); // R10

  AST_DONE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> doneIrq); // R10

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && ctlSel == 2'd2 && ctlWdata[1:0] == 2'b11) |=> (!busy && !donePulse)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(ctlWe && ctlSel == 2'd3 && ctlWdata[1])) |=> errFlag); // R8

endmodule

bind cmdstream_exec cmdx_checker #(.AW(AW)) i_cmdx_checker (
  .clk(clk), .rstN(rstN), .ctlWe(ctlWe), .ctlSel(ctlSel), .ctlWdata(ctlWdata),
  .busy(busy), .donePulse(donePulse), .doneIrq(doneIrq), .errFlag(errFlag),
  .regWe(regWe)
);

// File: tb/test_cmdstream_exec.sv
module test_cmdstream_exec;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;
  localparam int AW         = 6;
  localparam int SL_W       = 13;

  logic            clk = 1'b0;
  logic            rstN, memWe, ctlWe, vblankPulse;
  logic [AW-1:0]   memAddr, ctlWdata;
  logic [31:0]     memWdata;
  logic [1:0]      ctlSel;
  logic [SL_W-1:0] scanLine;
  logic            busy, donePulse, doneIrq, errFlag, regWe;
  logic [19:0]     regAddr;
  logic [31:0]     regData;
  logic [3:0]      regBe;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdstream_exec #(.MEM_WORDS(MEM_WORDS), .CNT_W(16), .CLK_PER_US(4), .SL_W(SL_W)) i_cmdstream_exec (
    .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .ctlWe(ctlWe), .ctlSel(ctlSel), .ctlWdata(ctlWdata), .scanLine(scanLine),
    .vblankPulse(vblankPulse), .busy(busy), .donePulse(donePulse), .doneIrq(doneIrq),
    .errFlag(errFlag), .regWe(regWe), .regAddr(regAddr), .regData(regData), .regBe(regBe)
  );

  int nChecks = 0;
  int nFails  = 0;
  int logN    = 0;
  int doneCnt = 0;
  logic [19:0] logAddr [16];
  logic [31:0] logData [16];
  logic [3:0]  logBe   [16];

  // observe the write port and done pulse away from the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (regWe && logN < 16) begin
      logAddr[logN] = regAddr;
      logData[logN] = regData;
      logBe[logN]   = regBe;
    end
    if (regWe) logN = logN + 1;
    if (donePulse) doneCnt = doneCnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hostMem(input int a, input logic [31:0] d);
    @(negedge clk);
    memWe = 1'b1; memAddr = AW'(a); memWdata = d;
    @(negedge clk);
    memWe = 1'b0;
  endtask

  task automatic hostCtl(input logic [1:0] s, input int v);
    @(negedge clk);
    ctlWe = 1'b1; ctlSel = s; ctlWdata = AW'(v);
    @(negedge clk);
    ctlWe = 1'b0;
  endtask

  task automatic clearMem();
    for (int i = 0; i < MEM_WORDS; i++) hostMem(i, 32'h0);
  endtask

  task automatic startRun(input int h, input int t);
    logN = 0;
    hostCtl(2'd0, h);
    hostCtl(2'd1, t);
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic pulseVb();
    @(negedge clk); vblankPulse = 1'b1;
    @(negedge clk); vblankPulse = 1'b0;
  endtask

  function automatic logic [31:0] hdr(input logic [7:0] op, input logic [3:0] be, input logic [19:0] off);
    return {op, be, off};
  endfunction

  typedef struct packed {
    logic [31:0] w0;
    logic [31:0] w1;
    logic [3:0]  nWr;
    logic [19:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic        err;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'hDEADBEEF, {8'h01, 4'hF, 20'h00A10}, 4'd1, 20'h00A10, 32'hDEADBEEF, 4'hF, 1'b0}, // R1
    '{32'h12345678, {8'h01, 4'h5, 20'hFFFFF}, 4'd1, 20'hFFFFF, 32'h12345678, 4'h5, 1'b0}, // R1
    '{32'h11111111, {8'h00, 4'hF, 20'h00123}, 4'd0, 20'h0,     32'h0,        4'h0, 1'b0}, // R2
    '{32'h00000007, {8'h03, 4'h0, 20'h00010}, 4'd0, 20'h0,     32'h0,        4'h0, 1'b1}, // R8
    '{32'h00000001, {8'h0A, 4'hF, 20'h00020}, 4'd0, 20'h0,     32'h0,        4'h0, 1'b1}, // R8
    '{32'h00000000, {8'h02, 4'h0, 20'h0},     4'd0, 20'h0,     32'h0,        4'h0, 1'b0}  // R4
  };

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finishRun();
  end

  initial begin
    int cyc, d0;
    rstN = 1'b0; memWe = 1'b0; ctlWe = 1'b0; vblankPulse = 1'b0;
    memAddr = '0; memWdata = '0; ctlSel = '0; ctlWdata = '0; scanLine = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, donePulse, doneIrq, errFlag, regWe} == 5'b0, "R12 reset outputs",
          32'({busy, donePulse, doneIrq, errFlag, regWe}), 32'h0);

    clearMem();
    // R9: no start without enable
    hostMem(0, 32'hA5A5A5A5); hostMem(1, hdr(8'h01, 4'hF, 20'h00777));
    startRun(0, 2);
    repeat (6) @(negedge clk);
    check(!busy && logN == 0, "R9 tail write without enable", 32'(logN), 32'h0);
    hostCtl(2'd2, 1);
    check(!busy, "R9 enable alone does not start", 32'(busy), 32'h0);

    // table of single-instruction programs
    foreach (VECS[k]) begin
      clearMem();
      hostMem(0, VECS[k].w0); hostMem(1, VECS[k].w1);
      hostCtl(2'd3, 3);
      d0 = doneCnt;
      startRun(0, 16);
      waitIdle(cyc);
      check(logN == int'(VECS[k].nWr), $sformatf("R1/R2/R8 vec%0d write count", k), 32'(logN), 32'(VECS[k].nWr));
      if (VECS[k].nWr != 0)
        check(logAddr[0] == VECS[k].addr && logData[0] == VECS[k].data && logBe[0] == VECS[k].be,
              $sformatf("R1 vec%0d write content", k), logData[0], VECS[k].data);
      check(errFlag == VECS[k].err, $sformatf("R8 vec%0d error flag", k), 32'(errFlag), 32'(VECS[k].err));
      check(doneCnt == d0 + 1, $sformatf("R10 vec%0d one done pulse", k), 32'(doneCnt - d0), 32'h1);
    end
    hostCtl(2'd3, 2);
    check(!errFlag, "R8 error flag cleared", 32'(errFlag), 32'h0);
    check(doneIrq, "R10 doneIrq held", 32'(doneIrq), 32'h1);
    hostCtl(2'd3, 1);
    check(!doneIrq, "R10 doneIrq cleared", 32'(doneIrq), 32'h0);

    // R3 odd indexed run with pad, then direct write
    clearMem();
    hostMem(0, 3); hostMem(1, hdr(8'h09, 4'h0, 20'h00300));
    hostMem(2, 32'hA1); hostMem(3, 32'hB2); hostMem(4, 32'hC3); hostMem(5, 32'h0);
    hostMem(6, 32'hD4); hostMem(7, hdr(8'h01, 4'h3, 20'h00400));
    startRun(0, 8);
    waitIdle(cyc);
    check(logN == 4, "R3 odd run write count", 32'(logN), 32'd4);
    check(logAddr[0] == 20'h300 && logAddr[2] == 20'h300 && logData[0] == 32'hA1 &&
          logData[1] == 32'hB2 && logData[2] == 32'hC3 && logBe[1] == 4'hF,
          "R3 odd run content", logData[2], 32'hC3);
    check(logAddr[3] == 20'h400 && logData[3] == 32'hD4 && logBe[3] == 4'h3,
          "R3 pad skipped before next pair", logData[3], 32'hD4);

    // R3 even indexed run
    clearMem();
    hostMem(0, 2); hostMem(1, hdr(8'h09, 4'h0, 20'h00310));
    hostMem(2, 32'hE1); hostMem(3, 32'hE2);
    hostMem(4, 32'hF5); hostMem(5, hdr(8'h01, 4'hF, 20'h00500));
    startRun(0, 6);
    waitIdle(cyc);
    check(logN == 3 && logData[1] == 32'hE2 && logAddr[2] == 20'h500 && logData[2] == 32'hF5,
          "R3 even run then direct write", logData[2], 32'hF5);

    // R4 microsecond stall
    clearMem();
    hostMem(0, 5); hostMem(1, hdr(8'h02, 4'h0, 20'h0));
    startRun(0, 2);
    waitIdle(cyc);
    check(cyc >= 20 && cyc <= 24, "R4 busy cycles for 5 us", 32'(cyc), 32'd20);

    // R5 vblank stall
    clearMem();
    hostMem(0, 2); hostMem(1, hdr(8'h04, 4'h0, 20'h0));
    hostMem(2, 32'h55); hostMem(3, hdr(8'h01, 4'hF, 20'h00600));
    startRun(0, 4);
    repeat (10) @(negedge clk);
    check(busy && logN == 0, "R5 stalled before vblank", 32'(logN), 32'h0);
    pulseVb();
    repeat (5) @(negedge clk);
    check(busy && logN == 0, "R5 stalled after one vblank", 32'(busy), 32'h1);
    pulseVb();
    waitIdle(cyc);
    check(logN == 1 && logAddr[0] == 20'h600, "R5 resumes after two vblanks", 32'(logN), 32'h1);

    // R6 inside window
    clearMem();
    scanLine = 13'd50;
    hostMem(0, {12'd200, 20'd100}); hostMem(1, hdr(8'h05, 4'h0, 20'h0));
    hostMem(2, 32'h66); hostMem(3, hdr(8'h01, 4'hF, 20'h00700));
    startRun(0, 4);
    repeat (10) @(negedge clk);
    check(busy && logN == 0, "R6 stalled below window", 32'(logN), 32'h0);
    scanLine = 13'd150;
    waitIdle(cyc);
    check(logN == 1 && logData[0] == 32'h66, "R6 resumes inside window", 32'(logN), 32'h1);

    // R6 upper bound split across both words (upper = 0x1200)
    clearMem();
    scanLine = 13'h1100;
    hostMem(0, {12'h200, 20'h00010}); hostMem(1, hdr(8'h05, 4'h0, 20'h00001));
    hostMem(2, 32'h77); hostMem(3, hdr(8'h01, 4'hF, 20'h00710));
    startRun(0, 4);
    repeat (20) @(negedge clk);
    check(!busy && logN == 1, "R6 split upper bound", 32'(logN), 32'h1);

    // R7 outside window
    clearMem();
    scanLine = 13'd150;
    hostMem(0, {12'd200, 20'd100}); hostMem(1, hdr(8'h06, 4'h0, 20'h0));
    hostMem(2, 32'h88); hostMem(3, hdr(8'h01, 4'hF, 20'h00720));
    startRun(0, 4);
    repeat (10) @(negedge clk);
    check(busy && logN == 0, "R7 stalled inside window", 32'(logN), 32'h0);
    scanLine = 13'd300;
    waitIdle(cyc);
    check(logN == 1 && logData[0] == 32'h88, "R7 resumes outside window", 32'(logN), 32'h1);

    // R11 halt during a stall, R9 nonzero head
    clearMem();
    hostCtl(2'd3, 3);
    hostMem(20, 5); hostMem(21, hdr(8'h04, 4'h0, 20'h0));
    hostMem(22, 32'h99); hostMem(23, hdr(8'h01, 4'hF, 20'h00800));
    d0 = doneCnt;
    startRun(20, 24);
    check(busy, "R9 busy the cycle after tail write", 32'(busy), 32'h1);
    repeat (5) @(negedge clk);
    hostCtl(2'd2, 3);
    check(!busy, "R11 halted", 32'(busy), 32'h0);
    repeat (5) pulseVb();
    check(doneCnt == d0 && !doneIrq && logN == 0, "R11 no done and no writes",
          32'(doneCnt - d0), 32'h0);

    // R9 restart from nonzero head with a direct write
    startRun(22, 24);
    waitIdle(cyc);
    check(logN == 1 && logAddr[0] == 20'h800 && logData[0] == 32'h99,
          "R9 run from nonzero head", 32'(logN), 32'h1);
    check(doneIrq, "R10 done after restart", 32'(doneIrq), 32'h1);

    finishRun();
  end

endmodule